// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block takes a DDR SDRAM from power-up to a usable state. After reset it sits idle, driving no-operation on the command pins, until an external flag reports that the supply and clock have settled (about 200 us). It then steps through a fixed order of commands: a no-operation, a precharge of all banks, two auto-refreshes, a load of the extended mode register and a load of the mode register. Between steps it holds no-operation for a counted number of clock cycles, given by the precharge time (tRP), the refresh cycle time (tRC) and the mode-register set time (tMRD). When the last wait has run out it raises a done flag. The rest of the controller uses that flag to take over the command bus.

The next state is decided from the current state and the settle flag. The command for that next state is registered on the same clock edge. As a result, a command appears on the pins in the first cycle of its state, with no extra decode register after the state register. Reset is asserted asynchronously and released through a two-stage synchronizer. The delay parameters must each be at least 2, and the address width must be at least 11 so that A10 exists.

Top module: `ddr_init_seq`

## Requirements
- R1: While `rst_n` is low, and afterwards while `pwr_stable` stays low, the outputs hold the idle value: {cs_n,ras_n,cas_n,we_n}=0111 (NOP), bank 0, address 0, `init_done` 0. Reset assertion takes effect without waiting for a clock edge.
- R2: At the first clock edge that samples `pwr_stable` high in idle, the block enters a NOP step for one cycle. The cycle after that it drives PRECHARGE ALL: code 0010, address bit 10 set, all other address bits 0, bank 0.
- R3: The first AUTO REFRESH (code 0001, bank 0, address 0) is driven exactly T_RP cycles after the precharge cycle.
- R4: The second AUTO REFRESH is driven exactly T_RC cycles after the first.
- R5: T_RC cycles after the second refresh, the block drives LOAD MODE (code 0000) with bank 01 and address EMR_VALUE.
- R6: T_MRD cycles after the extended load, the block drives LOAD MODE with bank 00 and address MR_VALUE.
- R7: `init_done` rises exactly T_MRD cycles after the mode load. It is low in every earlier cycle and stays high, with NOP on the pins, until the next reset.
- R8: Every cycle that is not one of the five command cycles drives NOP with bank 0 and address 0. Each command lasts exactly one cycle.
- R9: `pwr_stable` is consulted only in idle. Changing it after the sequence has started does not alter any output.
- R10: A reset in any cycle of the sequence returns the outputs to the idle value at once. A later rise of `pwr_stable` replays the whole sequence from the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all outputs change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_stable | input | 1 | High once the power-up settle time has elapsed |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_ba | output | BANK_W | Bank select; picks the mode register during loads |
| ddr_addr | output | ADDR_W | Address; carries A10 for precharge and the mode values |
| init_done | output | 1 | High once the sequence has completed |

## Verification
A wrong state or counter value shows up at the pins as a command that arrives early, late, twice or with the wrong bank or address. Because commands are registered straight from the next state, the error appears within one cycle of the state going wrong. A counter that loads the wrong value moves every later command by the same offset, so the refresh and mode-load cycles are compared against their exact arithmetic positions for two parameter sets. Every cycle is swept as a reset point, to catch state that survives a reset and misplaces the replayed sequence.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_NOP, ST_PRE, ST_WRP, ST_AR1, ST_WRC1, ST_AR2,
    ST_WRC2, ST_EMR, ST_WMR1, ST_MR, ST_WMR2, ST_DONE
  } init_state_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_LMR = 4'b0000;

  function automatic logic is_wait(init_state_e s);
    return (s == ST_WRP) || (s == ST_WRC1) || (s == ST_WRC2) ||
           (s == ST_WMR1) || (s == ST_WMR2);
  endfunction

endpackage

// File: rtl/ddr_init_rst_sync.sv
module ddr_init_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/ddr_init_wait_ctr.sv
module ddr_init_wait_ctr #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = load_i || (run_i && (cnt_q != '0));

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)      cnt_d = load_val_i;
    else if (cnt_en) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  // R3 R4 R6: a loaded delay is the one that is counted
  a_r3_load_taken: assert property (@(posedge clk) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)));
  a_r4_counts_down: assert property (@(posedge clk) disable iff (!rst_ni)
    (run_i && !load_i && !zero_o) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/ddr_init_fsm.sv
module ddr_init_fsm
  import ddr_init_pkg::*;
#(
  parameter int T_RP  = 3,
  parameter int T_RC  = 10,
  parameter int T_MRD = 2,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             stable_i,
  input  logic             zero_i,
  output init_state_e      next_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             run_o
);
  localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP - 2);
  localparam logic [CNT_W-1:0] LD_RC  = CNT_W'(T_RC - 2);
  localparam logic [CNT_W-1:0] LD_MRD = CNT_W'(T_MRD - 2);

  init_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (stable_i) state_d = ST_NOP;
      ST_NOP:  state_d = ST_PRE;
      ST_PRE:  state_d = ST_WRP;
      ST_WRP:  if (zero_i) state_d = ST_AR1;
      ST_AR1:  state_d = ST_WRC1;
      ST_WRC1: if (zero_i) state_d = ST_AR2;
      ST_AR2:  state_d = ST_WRC2;
      ST_WRC2: if (zero_i) state_d = ST_EMR;
      ST_EMR:  state_d = ST_WMR1;
      ST_WMR1: if (zero_i) state_d = ST_MR;
      ST_MR:   state_d = ST_WMR2;
      ST_WMR2: if (zero_i) state_d = ST_DONE;
      ST_DONE: state_d = ST_DONE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_d)
      ST_WRP:           load_val_o = LD_RP;
      ST_WRC1, ST_WRC2: load_val_o = LD_RC;
      default:          load_val_o = LD_MRD;
    endcase
  end

  assign load_o = is_wait(state_d) && !is_wait(state_q);
  assign run_o  = is_wait(state_q);
  assign next_o = state_d;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  a_r1_idle_holds: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_IDLE && !stable_i) |=> (state_q == ST_IDLE));
  a_r2_nop_then_pre: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_NOP) |=> (state_q == ST_PRE));
  a_r9_no_return_idle: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> (state_q != ST_IDLE));
  a_r7_done_after_mrd: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(state_q == ST_DONE) |-> ($past(state_q) == ST_WMR2));
endmodule

// File: rtl/ddr_init_cmd_enc.sv
module ddr_init_cmd_enc
  import ddr_init_pkg::*;
#(
  parameter int                ADDR_W    = 13,
  parameter int                BANK_W    = 2,
  parameter logic [ADDR_W-1:0] EMR_VALUE = '0,
  parameter logic [ADDR_W-1:0] MR_VALUE  = '0
) (
  input  init_state_e       state_i,
  output logic [3:0]        code_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);
  localparam logic [ADDR_W-1:0] A10_ONLY = ADDR_W'(1024);
  localparam logic [BANK_W-1:0] BANK_EMR = BANK_W'(1);

  always_comb begin
    code_o = CMD_NOP;
    bank_o = '0;
    addr_o = '0;
    unique case (state_i)
      ST_PRE: begin code_o = CMD_PRE; addr_o = A10_ONLY; end
      ST_AR1, ST_AR2: code_o = CMD_REF;
      ST_EMR: begin code_o = CMD_LMR; bank_o = BANK_EMR; addr_o = EMR_VALUE; end
      ST_MR:  begin code_o = CMD_LMR; addr_o = MR_VALUE; end
      default: ;
    endcase
  end

  assign done_o = (state_i == ST_DONE);
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int                ADDR_W    = 13,
  parameter int                BANK_W    = 2,
  parameter int                T_RP      = 3,
  parameter int                T_RC      = 10,
  parameter int                T_MRD     = 2,
  parameter logic [ADDR_W-1:0] EMR_VALUE = 13'h0000,
  parameter logic [ADDR_W-1:0] MR_VALUE  = 13'h0132
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_stable,
  output logic              ddr_cs_n,
  output logic              ddr_ras_n,
  output logic              ddr_cas_n,
  output logic              ddr_we_n,
  output logic [BANK_W-1:0] ddr_ba,
  output logic [ADDR_W-1:0] ddr_addr,
  output logic              init_done
);
  localparam int MAX_DLY = (T_RC > T_RP) ? ((T_RC > T_MRD) ? T_RC : T_MRD)
                                         : ((T_RP > T_MRD) ? T_RP : T_MRD);
  localparam int CNT_W   = $clog2(MAX_DLY) + 1;

  logic             rst_i;
  logic             zero;
  logic             ld;
  logic             run;
  logic [CNT_W-1:0] ld_val;
  init_state_e      nxt;
  logic [3:0]       code_d, code_q;
  logic [BANK_W-1:0] bank_d, bank_q;
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic             done_d, done_q;

  ddr_init_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_ni(rst_n), .rst_no(rst_i));

  ddr_init_fsm #(.T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_ni(rst_i), .stable_i(pwr_stable), .zero_i(zero),
    .next_o(nxt), .load_o(ld), .load_val_o(ld_val), .run_o(run));

  ddr_init_wait_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_ni(rst_i), .load_i(ld), .load_val_i(ld_val),
    .run_i(run), .zero_o(zero));

  ddr_init_cmd_enc #(.ADDR_W(ADDR_W), .BANK_W(BANK_W),
                     .EMR_VALUE(EMR_VALUE), .MR_VALUE(MR_VALUE)) u_enc (
    .state_i(nxt), .code_o(code_d), .bank_o(bank_d), .addr_o(addr_d),
    .done_o(done_d));

  // command of the state being entered is registered on the same edge
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      code_q <= CMD_NOP;
      bank_q <= '0;
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      code_q <= code_d;
      bank_q <= bank_d;
      addr_q <= addr_d;
      done_q <= done_d;
    end
  end

  assign {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} = code_q;
  assign ddr_ba    = bank_q;
  assign ddr_addr  = addr_q;
  assign init_done = done_q;

  a_r8_single_cycle_cmd: assert property (@(posedge clk) disable iff (!rst_i)
    (code_q != CMD_NOP) |=> (code_q == CMD_NOP));
  a_r8_nop_clean: assert property (@(posedge clk) disable iff (!rst_i)
    (code_q == CMD_NOP) |-> (bank_q == '0 && addr_q == '0));
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_i)
    init_done |=> init_done);
  a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rst_i)
    init_done |-> (code_q == CMD_NOP));
endmodule

// File: tb/ddr_init_seq_tb_top.sv
`timescale 1ns/1ps
module ddr_init_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stable = 1'b0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   ended = 1'b0;

  always #10 clk = ~clk;

  logic        a_cs, a_ras, a_cas, a_we, a_done, b_cs, b_ras, b_cas, b_we, b_done;
  logic [1:0]  a_ba, b_ba;
  logic [12:0] a_addr, b_addr;

  localparam int A_RP = 3, A_RC = 10, A_MRD = 2;
  localparam int B_RP = 2, B_RC = 4,  B_MRD = 3;
  localparam logic [12:0] A_EMR = 13'h0000, A_MR = 13'h0132;
  localparam logic [12:0] B_EMR = 13'h0002, B_MR = 13'h0021;

  ddr_init_seq dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_stable(stable),
    .ddr_cs_n(a_cs), .ddr_ras_n(a_ras), .ddr_cas_n(a_cas), .ddr_we_n(a_we),
    .ddr_ba(a_ba), .ddr_addr(a_addr), .init_done(a_done));

  ddr_init_seq #(.T_RP(B_RP), .T_RC(B_RC), .T_MRD(B_MRD),
                 .EMR_VALUE(B_EMR), .MR_VALUE(B_MR)) dut_b (
    .clk(clk), .rst_n(rst_n), .pwr_stable(stable),
    .ddr_cs_n(b_cs), .ddr_ras_n(b_ras), .ddr_cas_n(b_cas), .ddr_we_n(b_we),
    .ddr_ba(b_ba), .ddr_addr(b_addr), .init_done(b_done));

  localparam logic [19:0] IDLE_W = {4'b0111, 2'b00, 13'h0000, 1'b0};

  // {code, bank, addr, done}; t = cycles since the NOP step
  function automatic logic [19:0] exp_w(int t, int rp, int rc, int mrd,
                                        logic [12:0] emr, logic [12:0] mr);
    int a1 = 1 + rp;
    int a2 = a1 + rc;
    int e  = a2 + rc;
    int m  = e + mrd;
    int d  = m + mrd;
    if (t == 1)            return {4'b0010, 2'b00, 13'h0400, 1'b0};
    if (t == a1 || t == a2) return {4'b0001, 2'b00, 13'h0000, 1'b0};
    if (t == e)            return {4'b0000, 2'b01, emr, 1'b0};
    if (t == m)            return {4'b0000, 2'b00, mr, 1'b0};
    if (t >= d)            return {4'b0111, 2'b00, 13'h0000, 1'b1};
    return IDLE_W;
  endfunction

  function automatic string req_of(int t, int rp, int rc, int mrd);
    int a1 = 1 + rp;
    int e  = a1 + 2 * rc;
    if (t == 1)           return "R2";
    if (t == a1)          return "R3";
    if (t == a1 + rc)     return "R4";
    if (t == e)           return "R5";
    if (t == e + mrd)     return "R6";
    if (t >= e + 2 * mrd) return "R7";
    return "R8";
  endfunction

  task automatic check(string req, string who, logic [19:0] act, logic [19:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, who, act, exp);
    end
  endtask

  task automatic check_idle(string req);
    check(req, "A", {a_cs, a_ras, a_cas, a_we, a_ba, a_addr, a_done}, IDLE_W);
    check(req, "B", {b_cs, b_ras, b_cas, b_we, b_ba, b_addr, b_done}, IDLE_W);
  endtask

  // toggle: flag wiggles after start (R9); cut: reset at that step (R10)
  task automatic run_seq(int extra_idle, bit toggle, int cut);
    @(negedge clk);
    rst_n  = 1'b0;
    stable = 1'b0;
    #1 check_idle("R1");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4 + extra_idle; i++) begin
      @(negedge clk);
      check_idle("R1");
    end
    stable = 1'b1;
    for (int t = 0; t < 32; t++) begin
      @(negedge clk);
      check(toggle ? "R9" : req_of(t, A_RP, A_RC, A_MRD), "A",
            {a_cs, a_ras, a_cas, a_we, a_ba, a_addr, a_done},
            exp_w(t, A_RP, A_RC, A_MRD, A_EMR, A_MR));
      check(toggle ? "R9" : req_of(t, B_RP, B_RC, B_MRD), "B",
            {b_cs, b_ras, b_cas, b_we, b_ba, b_addr, b_done},
            exp_w(t, B_RP, B_RC, B_MRD, B_EMR, B_MR));
      if (toggle) stable = ~stable;
      if (t == cut) begin
        rst_n = 1'b0;
        #1 check_idle("R10");
        break;
      end
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    #1 check_idle("R1");
    for (int d = 0; d < 4; d++) run_seq(d, 1'b0, -1);
    run_seq(0, 1'b1, -1);
    for (int c = 0; c < 32; c++) run_seq(1, c[0], c);
    run_seq(0, 1'b0, -1);
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule